// File: doc/BRIEF.md
# Address-Prefixed Three-Wire Serial Control Slave

This block is the slave end of a three-wire serial link: a serial clock, a chip-enable and a data-in line, plus an open-drain data-out line. Every transfer has two parts. While chip-enable is low, the host shifts in an 8-bit address. It then raises chip-enable, and the data phase that follows is handled according to that address.

One address writes a 16-bit control word. A second address streams bytes to a downstream checker. A third address shifts a status word, loaded from a parallel port, out of the block. All three serial pins are oversampled by a much faster free-running system clock. They pass through two-stage synchronizers, and their edges are detected inside the block.

On the core side, the block presents three things: the latched control word, a one-cycle byte strobe with its byte, and a parallel load port for the outgoing status bits. The data-out pin is modelled as a pull-low enable. When that enable is 0, the line is released.

Top module: `addr_serial_slave`

## Requirements
- R1: The address is the last 8 bits sampled on rising serial-clock edges while chip-enable is low, first bit received in the most significant position. The mode is fixed when chip-enable rises and holds for the whole data phase, so a bit-reversed code does not select a mode.
- R2: Address code 0x5F (bits received 0,1,0,1,1,1,1,1) selects control write. A data phase of exactly 16 bits is latched onto `ctrlWord` when chip-enable falls, the first bit becoming bit 15.
- R3: A control-write data phase with fewer or more than 16 bits leaves `ctrlWord` unchanged.
- R4: Address code 0x3F (bits 0,0,1,1,1,1,1,1) selects checker input. Every 8th data bit yields `byteValid` with `byteData`, the first bit of the byte at bit 7. Trailing bits short of a byte are dropped, and `ctrlWord` is not touched.
- R5: Address code 0xDF (bits 1,1,0,1,1,1,1,1) selects status output. `txData` is loaded when chip-enable rises, and bit 15 is presented first. The next bit is presented after each falling serial-clock edge, so the host samples on rising edges.
- R6: `doDriveLow` is 1 only during an output-mode data phase while the current bit is 0. After 16 bits, and whenever chip-enable is low, the line is released.
- R7: Any other address ignores the whole data phase: no latch, no byte strobe, and the line stays released.
- R8: An active-low `rstN` clears the mode, the shift registers, the control word and the output, even in the middle of a transfer.
- R9: `byteValid` is high for exactly one system-clock cycle per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clIn | input | 1 | Serial clock pin |
| ceIn | input | 1 | Chip-enable pin |
| diIn | input | 1 | Serial data-in pin |
| txData | input | 16 | Status word to shift out in output mode |
| doDriveLow | output | 1 | 1 pulls the open-drain data-out low; 0 releases it |
| ctrlWord | output | 16 | Latched control word |
| byteValid | output | 1 | One-cycle strobe for a completed checker byte |
| byteData | output | 8 | Byte delivered with `byteValid` |

## Verification
The bench goes after the bit-count boundary of the control write: 15 and 17 bits must latch nothing, so a design that commits on any count of at least 16 would overwrite the word. It sends the control code bit-reversed, which a design that assembles the address in the wrong order would accept as a write. Checker traffic carries a partial trailing byte that must vanish, and a design that flushed it would emit a third strobe. The output test reads all 16 bits, then clocks once more and drops chip-enable. A design that presented bit 14 first, shifted on the rising edge, or left the pull-down active would show a wrong level at one of those samples.

// File: rtl/addr_serial_pkg.sv
package addr_serial_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_CTRL = 2'd1,
    MODE_CHK  = 2'd2,
    MODE_OUT  = 2'd3
  } modeT;

  // Strobes from the control unit to the datapath, all one cycle wide.
  typedef struct packed {
    logic sampleBit;   // take bitVal into the input shifter
    logic bitVal;      // synchronized data-in level
    logic byteDone;    // this sample completes a checker byte
    logic commitCtrl;  // copy the input shifter onto the control word
    logic loadTx;      // load the status word, start driving
    logic shiftTx;     // advance to the next outgoing bit
    logic dropTx;      // stop driving
  } strobeT;

endpackage

// File: rtl/addr_serial_ctrl.sv
module addr_serial_ctrl
  import addr_serial_pkg::*;
#(
  parameter int        ADDR_W      = 8,
  parameter int        CTRL_W      = 16,
  parameter int        BYTE_W      = 8,
  parameter int        SYNC_STAGES = 2,
  parameter logic [7:0] CODE_CTRL  = 8'h5F,
  parameter logic [7:0] CODE_CHK   = 8'h3F,
  parameter logic [7:0] CODE_OUT   = 8'hDF
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   clIn,
  input  logic   ceIn,
  input  logic   diIn,
  output strobeT st
);

  localparam int CNT_W  = $clog2(CTRL_W + 2);
  localparam int BCNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(CTRL_W + 1);
  localparam logic [BCNT_W-1:0] BYTE_END = BCNT_W'(BYTE_W - 1);

  // Pin synchronizers: bit 2 = clock, bit 1 = enable, bit 0 = data.
  logic [2:0] pinSync [SYNC_STAGES];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) pinSync[i] <= 3'b000;
    end else begin
      pinSync[0] <= {clIn, ceIn, diIn};
      for (int i = 1; i < SYNC_STAGES; i++) pinSync[i] <= pinSync[i-1];
    end
  end

  logic clS, ceS, diS, clPrev, cePrev;
  assign clS = pinSync[SYNC_STAGES-1][2];
  assign ceS = pinSync[SYNC_STAGES-1][1];
  assign diS = pinSync[SYNC_STAGES-1][0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clPrev <= 1'b0;
      cePrev <= 1'b0;
    end else begin
      clPrev <= clS;
      cePrev <= ceS;
    end
  end

  logic clRise, clFall, ceRise, ceFall;
  assign clRise = clS & ~clPrev;
  assign clFall = ~clS & clPrev;
  assign ceRise = ceS & ~cePrev;
  assign ceFall = ~ceS & cePrev;

  logic [ADDR_W-1:0] addrSh;
  modeT              mode, addrMode;
  logic [CNT_W-1:0]  ctrlCnt;
  logic [BCNT_W-1:0] byteCnt;

  always_comb begin
    unique case (addrSh)
      CODE_CTRL: addrMode = MODE_CTRL;
      CODE_CHK:  addrMode = MODE_CHK;
      CODE_OUT:  addrMode = MODE_OUT;
      default:   addrMode = MODE_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSh  <= '0;
      mode    <= MODE_NONE;
      ctrlCnt <= '0;
      byteCnt <= '0;
    end else if (ceFall) begin
      addrSh  <= '0;
      mode    <= MODE_NONE;
      ctrlCnt <= '0;
      byteCnt <= '0;
    end else if (ceRise) begin
      mode <= addrMode;
    end else if (clRise && !ceS) begin
      addrSh <= {addrSh[ADDR_W-2:0], diS};
    end else if (clRise && ceS) begin
      if (mode == MODE_CTRL && ctrlCnt != CNT_SAT) ctrlCnt <= ctrlCnt + 1'b1;
      if (mode == MODE_CHK) byteCnt <= (byteCnt == BYTE_END) ? '0 : byteCnt + 1'b1;
    end
  end

  always_comb begin
    st.bitVal     = diS;
    st.sampleBit  = clRise & ceS & (mode == MODE_CTRL || mode == MODE_CHK);
    st.byteDone   = clRise & ceS & (mode == MODE_CHK) & (byteCnt == BYTE_END);
    st.commitCtrl = ceFall & (mode == MODE_CTRL) & (ctrlCnt == CNT_FULL);
    st.loadTx     = ceRise & (addrMode == MODE_OUT);
    st.shiftTx    = clFall & ceS & (mode == MODE_OUT);
    st.dropTx     = ceFall;
  end

  // R1: the mode chosen at the enable rise is held through the data phase.
  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (ceS && $past(ceS && cePrev)) |-> $stable(mode));

endmodule

// File: rtl/addr_serial_dp.sv
module addr_serial_dp
  import addr_serial_pkg::*;
#(
  parameter int CTRL_W = 16,
  parameter int BYTE_W = 8,
  parameter int TX_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            st,
  input  logic [TX_W-1:0]   txData,
  output logic              doDriveLow,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData
);

  logic [CTRL_W-1:0] dataSh;
  logic [TX_W-1:0]   txSh;
  logic              txOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSh    <= '0;
      ctrlWord  <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= st.byteDone;
      if (st.sampleBit) dataSh <= {dataSh[CTRL_W-2:0], st.bitVal};
      if (st.byteDone) byteData <= {dataSh[BYTE_W-2:0], st.bitVal};
      if (st.commitCtrl) ctrlWord <= dataSh;
    end
  end

  // Outgoing shifter: ones fill in behind, so the line releases after the last bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '1;
      txOn <= 1'b0;
    end else if (st.loadTx) begin
      txSh <= txData;
      txOn <= 1'b1;
    end else if (st.dropTx) begin
      txOn <= 1'b0;
    end else if (st.shiftTx) begin
      txSh <= {txSh[TX_W-2:0], 1'b1};
    end
  end

  assign doDriveLow = txOn & ~txSh[TX_W-1];

  // R2, R3: the control word moves only on a commit strobe.
  a_r2_ctrl_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlWord) |-> $past(st.commitCtrl));

  // R4: a byte strobe follows a completed byte.
  a_r4_byte_from_strobe: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(st.byteDone));

  // R9: the byte strobe lasts one cycle.
  a_r9_byte_single: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R5: a shift request only arrives while a loaded word is being driven.
  a_r5_shift_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    st.shiftTx |-> txOn);

endmodule

// File: rtl/addr_serial_slave.sv
module addr_serial_slave
  import addr_serial_pkg::*;
#(
  parameter int CTRL_W = 16,
  parameter int BYTE_W = 8,
  parameter int TX_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clIn,
  input  logic              ceIn,
  input  logic              diIn,
  input  logic [TX_W-1:0]   txData,
  output logic              doDriveLow,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData
);

  strobeT st;

  addr_serial_ctrl #(.ADDR_W(8), .CTRL_W(CTRL_W), .BYTE_W(BYTE_W), .SYNC_STAGES(2)) uCtrl (
    .clk (clk),
    .rstN(rstN),
    .clIn(clIn),
    .ceIn(ceIn),
    .diIn(diIn),
    .st  (st)
  );

  addr_serial_dp #(.CTRL_W(CTRL_W), .BYTE_W(BYTE_W), .TX_W(TX_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .txData    (txData),
    .doDriveLow(doDriveLow),
    .ctrlWord  (ctrlWord),
    .byteValid (byteValid),
    .byteData  (byteData)
  );

endmodule

// File: tb/addr_serial_slave_test.sv
module addr_serial_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;   // system cycles per serial half-period
  localparam int NVEC = 8;
  // {address, bit count, data, expected control word afterwards}
  localparam logic [63:0] VEC [NVEC] = '{
    {8'h5F, 8'd16, 32'h0000A5C3, 16'hA5C3},
    {8'h5F, 8'd15, 32'h00001234, 16'hA5C3},
    {8'h5F, 8'd17, 32'h0001FFFF, 16'hA5C3},
    {8'h5E, 8'd16, 32'h00001111, 16'hA5C3},
    {8'hFA, 8'd16, 32'h00002222, 16'hA5C3},
    {8'h5F, 8'd16, 32'h00001234, 16'h1234},
    {8'hFF, 8'd16, 32'h0000BEEF, 16'h1234},
    {8'h5F, 8'd16, 32'h0000FFFF, 16'hFFFF}
  };

  logic clk = 1'b0, rstN = 1'b0, clIn = 1'b0, ceIn = 1'b0, diIn = 1'b0;
  logic [15:0] txData = 16'h0000;
  logic doDriveLow, byteValid;
  logic [15:0] ctrlWord;
  logic [7:0]  byteData;

  int errors = 0, checks = 0;
  int capCnt = 0, runLen = 0, maxRun = 0;
  logic [7:0] capBytes [4];

  addr_serial_slave uut (
    .clk(clk), .rstN(rstN), .clIn(clIn), .ceIn(ceIn), .diIn(diIn),
    .txData(txData), .doDriveLow(doDriveLow), .ctrlWord(ctrlWord),
    .byteValid(byteValid), .byteData(byteData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (byteValid) begin
      if (capCnt < 4) capBytes[capCnt] = byteData;
      capCnt = capCnt + 1;
      runLen = runLen + 1;
      if (runLen > maxRun) maxRun = runLen;
    end else begin
      runLen = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic clPulse(input logic b);
    diIn = b;
    waitHalf();
    clIn = 1'b1;
    waitHalf();
    clIn = 1'b0;
  endtask

  task automatic sendAddr(input logic [7:0] a);
    ceIn = 1'b0;
    for (int i = 7; i >= 0; i--) clPulse(a[i]);
    waitHalf();
    ceIn = 1'b1;
    waitHalf();
  endtask

  task automatic endFrame();
    waitHalf();
    ceIn = 1'b0;
    waitHalf();
    waitHalf();
  endtask

  function automatic string vecReq(input logic [7:0] a, input int n);
    if (a == 8'hFA) return "R1";
    if (a != 8'h5F) return "R7";
    if (n != 16) return "R3";
    return "R2";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8: reset state
    check(ctrlWord == 16'h0, "R8 reset ctrlWord", ctrlWord, 0);
    check(doDriveLow == 1'b0 && byteValid == 1'b0, "R8 reset outputs", {doDriveLow, byteValid}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // Control-write table: R1 R2 R3 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] a, n;
      logic [31:0] d;
      logic [15:0] e;
      {a, n, d, e} = VEC[v];
      sendAddr(a);
      for (int i = int'(n) - 1; i >= 0; i--) clPulse(d[i]);
      check(doDriveLow == 1'b0, "R6 released in input phase", doDriveLow, 0);
      endFrame();
      check(ctrlWord == e, vecReq(a, int'(n)), ctrlWord, e);
    end

    // Checker input: R4, R9
    capCnt = 0;
    sendAddr(8'h3F);
    for (int i = 7; i >= 0; i--) clPulse(8'h96 >> i);
    for (int i = 7; i >= 0; i--) clPulse(8'h0F >> i);
    for (int i = 3; i >= 0; i--) clPulse(4'hA >> i);
    endFrame();
    check(capCnt == 2, "R4 byte count", capCnt, 2);
    check(capBytes[0] == 8'h96, "R4 first byte", capBytes[0], 8'h96);
    check(capBytes[1] == 8'h0F, "R4 second byte", capBytes[1], 8'h0F);
    check(ctrlWord == 16'hFFFF, "R4 control word untouched", ctrlWord, 16'hFFFF);
    check(maxRun == 1, "R9 strobe width", maxRun, 1);

    // Status output: R5, R6
    txData = 16'hB38E;
    sendAddr(8'hDF);
    for (int i = 15; i >= 0; i--) begin
      check(doDriveLow == ~txData[i], "R5 output bit", doDriveLow, ~txData[i]);
      waitHalf();
      clIn = 1'b1;
      waitHalf();
      clIn = 1'b0;
      waitHalf();
    end
    check(doDriveLow == 1'b0, "R6 released after last bit", doDriveLow, 0);
    endFrame();
    check(doDriveLow == 1'b0, "R6 released after enable low", doDriveLow, 0);

    // Output mode with a zero first bit, then reset mid-frame: R8
    txData = 16'h0F0F;
    sendAddr(8'hDF);
    check(doDriveLow == 1'b1, "R5 first bit zero drives low", doDriveLow, 1);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(doDriveLow == 1'b0 && ctrlWord == 16'h0, "R8 reset mid transfer", {doDriveLow, ctrlWord}, 0);
    rstN = 1'b1;
    ceIn = 1'b0;
    repeat (2 * HALF) @(negedge clk);

    // Unmatched address produces no bytes and no drive: R7
    capCnt = 0;
    sendAddr(8'h3E);
    for (int i = 7; i >= 0; i--) clPulse(8'h00 >> i);
    check(doDriveLow == 1'b0, "R7 line released", doDriveLow, 0);
    endFrame();
    check(capCnt == 0 && ctrlWord == 16'h0, "R7 no effect", {capCnt[15:0], ctrlWord}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule